// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block watches a free-running 64-bit system time value and escalates in two steps when software stops servicing it. Software programs an absolute first-stage deadline and a second-stage delta. Once the time value moves strictly beyond the first-stage deadline, the block raises a level interrupt and arms the second stage. The second-stage deadline is the first-stage deadline plus the delta, and the sum saturates at all-ones. If the time value then moves strictly beyond it while the second stage is armed, the block raises a sticky system-reset request.

Servicing the watchdog means writing a new first-stage deadline. Any write to either 32-bit half of that register drops the interrupt and disarms the second stage. Both 64-bit registers come out of reset as all-ones. No time value can exceed that, so the watchdog stays silent until software programs it. Each register is reached as two 32-bit words. A 32-bit host updates a deadline safely by writing all-ones to the low word, then the high word, then the low word.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, all four register words read 0xFFFFFFFF, and both `irq_o` and `rst_req_o` are low. They stay low for any time value while nothing is written.
- R2: The word index is `reg_addr[3:2]`. Index 0 is the stage-1 deadline bits 31:0 and index 1 is its bits 63:32. Index 2 is the stage-2 delta bits 31:0 and index 3 is its bits 63:32. A write lands at the next clock edge, and `reg_rdata` returns the addressed word combinationally.
- R3: `irq_o` rises at the clock edge that ends a cycle in which `time_i` is strictly greater, unsigned, than the stage-1 deadline. A time equal to the deadline does not fire it.
- R4: Once high, `irq_o` stays high until the stage-1 deadline is written.
- R5: A write to either half of the stage-1 deadline clears `irq_o` at that edge and disarms stage 2, even when the value written is unchanged. From the next cycle, the new value is compared against `time_i` again.
- R6: `rst_req_o` rises at the edge that ends a cycle in which `irq_o` is high, `time_i` is strictly greater than the stage-2 deadline, and no stage-1 write occurs.
- R7: The stage-2 deadline is the stage-1 deadline plus the delta, saturated at 0xFFFFFFFFFFFFFFFF. An overflowing sum therefore never requests reset.
- R8: `rst_req_o` stays high until `rst_n` is asserted. Register writes do not clear it.
- R9: `rst_req_o` never rises in the same edge as `irq_o`. Stage 2 must be armed for a full cycle first.
- R10: The three-write update order (all-ones to the low word, then the high word, then the low word) raises no interrupt partway through, provided the time value lies below each intermediate deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Shared system time value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Stage-1 expiry interrupt (level) |
| rst_req_o | output | 1 | Stage-2 system-reset request (sticky) |

## Verification
The bench places time exactly on each deadline and then one tick past it. An off-by-one comparison would fire early or late there. It programs a deadline near the top of the time range with a delta that overflows, so a wrapping adder would request reset at once. It jumps time past both deadlines in a single step, which catches a design that fires reset in the same edge as the interrupt. It services the watchdog with an unchanged value and with a new value between the two deadlines. A design that compared values instead of detecting the write, or that left stage 2 armed, would then keep the interrupt or raise reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int TIME_W_DEF = 64;
   localparam int BUS_W_DEF  = 32;
   localparam int ADDR_W_DEF = 4;

   // Unsigned addition that clamps at all-ones instead of wrapping.
   function automatic logic [TIME_W_DEF-1:0] sat_add(input logic [TIME_W_DEF-1:0] a,
                                                      input logic [TIME_W_DEF-1:0] b);
      logic [TIME_W_DEF:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[TIME_W_DEF] ? {TIME_W_DEF{1'b1}} : s[TIME_W_DEF-1:0];
   endfunction
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile #(
   parameter int TIME_W = 64,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   output logic [TIME_W-1:0] cmp_o,
   output logic [TIME_W-1:0] dlt_o,
   output logic              cmp_wr_o
);
   localparam int NHALF    = TIME_W / BUS_W;
   localparam int NWORD    = 2 * NHALF;
   localparam int IDX_W    = (NWORD > 1) ? $clog2(NWORD) : 1;
   localparam int WORD_LSB = $clog2(BUS_W / 8);

   if (NHALF * BUS_W != TIME_W) begin : g_bad_width
      $error("TIME_W must be a whole multiple of BUS_W");
   end
   if (ADDR_W < WORD_LSB + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register words");
   end

   logic [IDX_W-1:0] widx;
   logic [BUS_W-1:0] cmp_w [NHALF];
   logic [BUS_W-1:0] dlt_w [NHALF];

   assign widx     = addr_i[WORD_LSB +: IDX_W];
   assign cmp_wr_o = wr_i && (int'(widx) < NHALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int h = 0; h < NHALF; h++) begin
            cmp_w[h] <= '1;
            dlt_w[h] <= '1;
         end
      end else if (wr_i) begin
         for (int h = 0; h < NHALF; h++) begin
            if (int'(widx) == h)         cmp_w[h] <= wdata_i;
            if (int'(widx) == NHALF + h) dlt_w[h] <= wdata_i;
         end
      end
   end

   for (genvar h = 0; h < NHALF; h++) begin : g_pack
      assign cmp_o[h*BUS_W +: BUS_W] = cmp_w[h];
      assign dlt_o[h*BUS_W +: BUS_W] = dlt_w[h];
   end

   always_comb begin
      rdata_o = '0;
      for (int h = 0; h < NHALF; h++) begin
         if (int'(widx) == h)         rdata_o = cmp_w[h];
         if (int'(widx) == NHALF + h) rdata_o = dlt_w[h];
      end
   end
endmodule

// File: rtl/wdog_deadline.sv
module wdog_deadline #(
   parameter int TIME_W = 64
) (
   input  logic [TIME_W-1:0] cmp_i,
   input  logic [TIME_W-1:0] dlt_i,
   output logic [TIME_W-1:0] dl_o
);
   logic [TIME_W:0] sum;
   assign sum  = {1'b0, cmp_i} + {1'b0, dlt_i};
   assign dl_o = sum[TIME_W] ? {TIME_W{1'b1}} : sum[TIME_W-1:0];
endmodule

// File: rtl/wdog_stages.sv
module wdog_stages #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_i,
   input  logic [TIME_W-1:0] cmp_i,
   input  logic [TIME_W-1:0] dl_i,
   input  logic              cmp_wr_i,
   output logic              irq_o,
   output logic              rst_req_o
);
   logic s1_pass, s2_pass;
   assign s1_pass = time_i > cmp_i;
   assign s2_pass = time_i > dl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         if (cmp_wr_i)     irq_o <= 1'b0;
         else if (s1_pass) irq_o <= 1'b1;
         if (irq_o && s2_pass && !cmp_wr_i) rst_req_o <= 1'b1;
      end
   end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
   parameter int TIME_W = wdog_pkg::TIME_W_DEF,
   parameter int BUS_W  = wdog_pkg::BUS_W_DEF,
   parameter int ADDR_W = wdog_pkg::ADDR_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_i,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              irq_o,
   output logic              rst_req_o
);
   logic [TIME_W-1:0] cmp_val, dlt_val, deadline;
   logic              cmp_wr;

   wdog_regfile #(.TIME_W(TIME_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cmp_o(cmp_val),
      .dlt_o(dlt_val), .cmp_wr_o(cmp_wr)
   );

   wdog_deadline #(.TIME_W(TIME_W)) u_dl (
      .cmp_i(cmp_val), .dlt_i(dlt_val), .dl_o(deadline)
   );

   wdog_stages #(.TIME_W(TIME_W)) u_stg (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .cmp_i(cmp_val),
      .dl_i(deadline), .cmp_wr_i(cmp_wr), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
   parameter int TIME_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TIME_W-1:0] time_i,
   input logic [TIME_W-1:0] cmp,
   input logic [TIME_W-1:0] dl,
   input logic              cmp_wr,
   input logic              irq,
   input logic              rst_req
);
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(time_i > cmp) && !$past(cmp_wr)); // R3
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !cmp_wr |=> irq); // R4
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !irq); // R5
   AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(irq) && $past(time_i > dl)); // R6
   AST_DL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      dl >= cmp); // R7
   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req); // R8
   AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> !$rose(irq)); // R9
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.TIME_W(TIME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .time_i(time_i), .cmp(cmp_val), .dl(deadline),
   .cmp_wr(cmp_wr), .irq(irq_o), .rst_req(rst_req_o)
);

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_i = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, rst_req_o;

   int checks = 0, failures = 0, cyc = 0;
   logic [63:0] tnow = '0;
   logic [63:0] m_cmp = '1, m_dlt = '1;
   logic        m_irq = 1'b0, m_rst = 1'b0;

   always #4 clk = ~clk;

   wdog_two_stage uut (
      .clk(clk), .rst_n(rst_n), .time_i(time_i), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   function automatic logic [63:0] sat(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[64] ? 64'hFFFF_FFFF_FFFF_FFFF : s[63:0];
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // One clock: drive at negedge, update the model at posedge, settle.
   task automatic cyc1(input logic w, input logic [3:0] a, input logic [31:0] d);
      logic        cw, nxt_rst;
      logic [63:0] dl;
      @(negedge clk);
      reg_wr = w; reg_addr = a; reg_wdata = d; time_i = tnow;
      @(posedge clk);
      cw      = w && (a[3] == 1'b0);
      dl      = sat(m_cmp, m_dlt);
      nxt_rst = m_rst | (!cw && m_irq && (tnow > dl));
      m_irq   = cw ? 1'b0 : (m_irq | (tnow > m_cmp));
      m_rst   = nxt_rst;
      if (w) begin
         case (a[3:2])
            2'd0: m_cmp[31:0]  = d;
            2'd1: m_cmp[63:32] = d;
            2'd2: m_dlt[31:0]  = d;
            default: m_dlt[63:32] = d;
         endcase
      end
      #1;
      reg_wr = 1'b0;
   endtask

   task automatic idle(); cyc1(1'b0, 4'h0, 32'h0); endtask
   task automatic wr(input logic [3:0] a, input logic [31:0] d); cyc1(1'b1, a, d); endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 1'b0;
      m_cmp = '1; m_dlt = '1; m_irq = 1'b0; m_rst = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 irq", {63'h0, irq_o}, 64'h0);
      chk("R1 rst", {63'h0, rst_req_o}, 64'h0);
      rd("R1 word0", 4'h0, 32'hFFFF_FFFF);
      rd("R1 word1", 4'h4, 32'hFFFF_FFFF);
      rd("R1 word2", 4'h8, 32'hFFFF_FFFF);
      rd("R1 word3", 4'hC, 32'hFFFF_FFFF);
      tnow = 64'hFFFF_FFFF_FFFF_FFFE;
      repeat (3) idle();
      chk("R1 quiet irq", {63'h0, irq_o}, 64'h0);

      // R10 / R2: three-write update, then delta
      tnow = 64'd1000;
      wr(4'h0, 32'hFFFF_FFFF); chk("R10 step1 irq", {63'h0, irq_o}, 64'h0);
      wr(4'h4, 32'h0);         chk("R10 step2 irq", {63'h0, irq_o}, 64'h0);
      wr(4'h0, 32'd1010);      chk("R10 step3 irq", {63'h0, irq_o}, 64'h0);
      wr(4'h8, 32'd5);
      wr(4'hC, 32'h0);
      rd("R2 cmp lo", 4'h0, 32'd1010);
      rd("R2 cmp hi", 4'h4, 32'h0);
      rd("R2 dlt lo", 4'h8, 32'd5);
      rd("R2 dlt hi", 4'hC, 32'h0);

      // R3: equal does not fire, one past does
      tnow = 64'd1010; idle();
      chk("R3 equal", {63'h0, irq_o}, 64'h0);
      tnow = 64'd1011; idle();
      chk("R3 past", {63'h0, irq_o}, 64'h1);
      tnow = 64'd1013; idle(); idle();
      chk("R4 hold", {63'h0, irq_o}, 64'h1);
      chk("R6 early", {63'h0, rst_req_o}, 64'h0);
      // R6: deadline 1015
      tnow = 64'd1015; idle();
      chk("R6 equal", {63'h0, rst_req_o}, 64'h0);
      tnow = 64'd1016; idle();
      chk("R6 past", {63'h0, rst_req_o}, 64'h1);
      // R5 / R8: rewrite with unchanged value
      wr(4'h4, 32'h0);
      chk("R5 clear", {63'h0, irq_o}, 64'h0);
      chk("R8 sticky", {63'h0, rst_req_o}, 64'h1);
      idle();
      chk("R5 refire", {63'h0, irq_o}, 64'h1);

      // R5: cancel between the two deadlines
      do_reset();
      tnow = 64'd2000;
      wr(4'h4, 32'h0); wr(4'h0, 32'd2010);
      wr(4'h8, 32'd20); wr(4'hC, 32'h0);
      tnow = 64'd2011; idle();
      chk("R3 armed", {63'h0, irq_o}, 64'h1);
      tnow = 64'd2025; wr(4'h0, 32'd5000);
      tnow = 64'd2040; repeat (4) idle();
      chk("R5 cancel irq", {63'h0, irq_o}, 64'h0);
      chk("R5 cancel rst", {63'h0, rst_req_o}, 64'h0);

      // R7: overflowing deadline sum saturates
      do_reset();
      tnow = 64'hFFFF_FFFF_FFFF_FFFB;
      wr(4'h0, 32'hFFFF_FFF0);
      wr(4'h8, 32'h20); wr(4'hC, 32'h0);
      chk("R7 irq", {63'h0, irq_o}, 64'h1);
      tnow = 64'hFFFF_FFFF_FFFF_FFFF; repeat (4) idle();
      chk("R7 no reset", {63'h0, rst_req_o}, 64'h0);

      // R9: both deadlines passed in one step
      do_reset();
      tnow = 64'd100;
      wr(4'h8, 32'h0); wr(4'hC, 32'h0);
      wr(4'h4, 32'h0); wr(4'h0, 32'd50);
      idle();
      chk("R9 irq first", {63'h0, irq_o}, 64'h1);
      chk("R9 no rst yet", {63'h0, rst_req_o}, 64'h0);
      idle();
      chk("R6 rst next", {63'h0, rst_req_o}, 64'h1);

      // Random phase against the model
      do_reset();
      tnow = 64'h0000_0001_FFFF_FE00;
      wr(4'h4, 32'h1); wr(4'hC, 32'h0);
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         tnow = tnow + 64'($urandom_range(0, 3));
         if (r < 3) begin
            logic [63:0] tgt;
            tgt = tnow + 64'($urandom_range(0, 60));
            if (tgt[63:32] != m_cmp[63:32]) wr(4'h4, tgt[63:32]);
            else wr(4'h0, tgt[31:0]);
         end else if (r < 5) begin
            wr(4'h8, 32'($urandom_range(0, 40)));
         end else if (r == 5 && $urandom_range(0, 9) == 0) begin
            do_reset();
            wr(4'h4, tnow[63:32]); wr(4'hC, 32'h0);
         end else begin
            idle();
         end
         chk("R3 R4 R5 random irq", {63'h0, irq_o}, {63'h0, m_irq});
         chk("R6 R8 random rst", {63'h0, rst_req_o}, {63'h0, m_rst});
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule